// File: doc/BRIEF.md
# I2C Master Byte FIFO and Interrupt Block

This block sits between a register bus and an I2C master protocol engine. It holds two byte queues, 128 entries each: a transmit queue filled by software through a data register and drained by the engine, and a receive queue filled by the engine and drained by software through a second data register. Software programs a high-water and a low-water threshold, reads both occupancies, and can empty both queues at once through a reset bit in the FIFO-control register.

An interrupt status register latches the queue conditions: receive level at or above the high-water mark, transmit queue drained, and transmit queue full. It also latches the engine's event pulses: address not acknowledged, address acknowledged, data done, arbitration lost and bus error. Each status bit is cleared by writing a one to it. A matching enable register selects which latched bits drive the single interrupt output. In a write transfer, software refills the transmit queue when the drained interrupt fires. In a read transfer, it empties the receive queue when the high-water interrupt fires.

Top module: `mfifo_top`

## Requirements
- R1: Register map by word address on `reg_addr`. 0: a write pushes `reg_wdata[7:0]` into the transmit queue. 1: a read pops the receive queue and returns the byte in `reg_rdata[7:0]`. 2: FIFO control, with high threshold [15:8] and low threshold [7:0] read back and bit 16 a write-only queue reset. 3: occupancy, with receive count in [7:0] and transmit count in [15:8]. 4: interrupt enable. 5: interrupt status. Every other address reads 0, and all unused bits read 0.
- R2: Each queue holds 128 bytes. A push into a full queue is dropped, and both the occupancy (128) and the stored bytes stay unchanged.
- R3: Bytes leave each queue in the order they entered: register bus to `tx_byte` for transmit, and `rx_byte` to register reads for receive.
- R4: A register pop from an empty receive queue returns 0 and leaves the count at 0. With the transmit queue empty, `tx_avail` is 0, `tx_byte` is 0, and an engine pop has no effect.
- R5: Writing 1 to FIFO-control bit 16 empties both queues at the next clock edge. The same write still loads both thresholds, and the interrupt enables do not change.
- R6: Status bit 2 sets on every clock while the high threshold is nonzero and the receive count is at or above it. Clearing it while the condition holds lets it set again. A threshold of 1 sets it once one received byte is present.
- R7: Status bit 3 sets when an engine pop removes the last transmit byte.
- R8: Status bit 4 sets while the transmit queue holds 128 bytes.
- R9: The engine event pulses latch into status bits 25 (address not acknowledged), 13 (address acknowledged), 12 (data done), 11 (arbitration lost) and 0 (bus error).
- R10: Status bits latch whether or not they are enabled. Writing 1 to a status bit clears it. A set in the same cycle as a clear wins, and reading all zeros means nothing is pending.
- R11: `irq` is high exactly when some status bit and its enable bit are both 1. The enable register keeps only the eight defined bits, so writing all ones reads back 0x0200381D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| tx_pop | input | 1 | Engine takes the transmit head byte |
| tx_byte | output | 8 | Transmit head byte, 0 when empty |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_space | output | 1 | Receive queue not full |
| ev_addr_nack | input | 1 | Event pulse: address not acknowledged |
| ev_addr_ack | input | 1 | Event pulse: address acknowledged |
| ev_done | input | 1 | Event pulse: data done |
| ev_arb_lost | input | 1 | Event pulse: arbitration lost |
| ev_bus_err | input | 1 | Event pulse: bus error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high together. They also assume that the engine event inputs are single-cycle pulses sampled at the clock edge, and that the enable register is not written in the same cycle as a queue reset. The bench drives one register access, one engine action or one event pulse per operation, always at the falling edge. It holds every strobe low for a cycle between operations. It samples the combinational outputs `reg_rdata`, `tx_byte` and `irq` just after the falling edge, before the edge that acts on them.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
  localparam int IRQ_W   = 32;
  localparam int B_NACK  = 25;
  localparam int B_AACK  = 13;
  localparam int B_DONE  = 12;
  localparam int B_ARB   = 11;
  localparam int B_FULL  = 4;
  localparam int B_EMPTY = 3;
  localparam int B_HIGH  = 2;
  localparam int B_BERR  = 0;
  localparam logic [IRQ_W-1:0] IRQ_MASK =
    (IRQ_W'(1) << B_NACK) | (IRQ_W'(1) << B_AACK) | (IRQ_W'(1) << B_DONE) |
    (IRQ_W'(1) << B_ARB)  | (IRQ_W'(1) << B_FULL) | (IRQ_W'(1) << B_EMPTY) |
    (IRQ_W'(1) << B_HIGH) | (IRQ_W'(1) << B_BERR);
  localparam int FLUSH_BIT = 16;

  typedef enum logic [2:0] {
    RA_TXDATA = 3'd0,
    RA_RXDATA = 3'd1,
    RA_FCTL   = 3'd2,
    RA_LEVEL  = 3'd3,
    RA_IEN    = 3'd4,
    RA_ISTAT  = 3'd5
  } reg_addr_e;

  // high-water condition: a zero threshold disables the event
  function automatic logic hi_reached(input logic [7:0] lvl, input logic [7:0] thr);
    return (thr != 8'd0) && (lvl >= thr);
  endfunction

  // write-one-to-clear update with set taking priority
  function automatic logic [IRQ_W-1:0] w1c_next(input logic [IRQ_W-1:0] cur,
                                                input logic [IRQ_W-1:0] clr,
                                                input logic [IRQ_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mfifo_byte_q.sv
module mfifo_byte_q #(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         push_ok,
  output logic                         pop_ok
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign push_ok = push && (count != CNT_W'(DEPTH)) && !flush;
  assign pop_ok  = pop  && (count != '0) && !flush;
  assign head    = (count == '0) ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= adv(wp);
      if (pop_ok)  rp <= adv(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mfifo_irq.sv
module mfifo_irq
  import mfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] wdata,
  input  logic [IRQ_W-1:0] set_vec,
  output logic [IRQ_W-1:0] en,
  output logic [IRQ_W-1:0] stat,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_vec;

  assign clr_vec = clr_wr ? (wdata & IRQ_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      stat <= '0;
    end else begin
      if (en_wr) en <= wdata & IRQ_MASK;
      stat <= w1c_next(stat, clr_vec, set_vec & IRQ_MASK);
    end
  end

  assign irq = |(stat & en);
endmodule

// File: rtl/mfifo_top.sv
module mfifo_top
  import mfifo_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic        rx_space,
  input  logic        ev_addr_nack,
  input  logic        ev_addr_ack,
  input  logic        ev_done,
  input  logic        ev_arb_lost,
  input  logic        ev_bus_err,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  // decoded register accesses
  logic tx_push_req, rx_pop_req, fctl_wr, ien_wr, istat_wr, flush;
  assign tx_push_req = reg_wr && (reg_addr == RA_TXDATA);
  assign rx_pop_req  = reg_rd && (reg_addr == RA_RXDATA);
  assign fctl_wr     = reg_wr && (reg_addr == RA_FCTL);
  assign ien_wr      = reg_wr && (reg_addr == RA_IEN);
  assign istat_wr    = reg_wr && (reg_addr == RA_ISTAT);
  assign flush       = fctl_wr && reg_wdata[FLUSH_BIT];

  logic [7:0] hi_thr, lo_thr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_thr <= '0;
      lo_thr <= '0;
    end else if (fctl_wr) begin
      hi_thr <= reg_wdata[15:8];
      lo_thr <= reg_wdata[7:0];
    end
  end

  // queues
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [7:0]       rx_head;

  mfifo_byte_q #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push_req), .push_data(reg_wdata[7:0]),
    .pop(tx_pop), .head(tx_byte), .count(tx_cnt),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  mfifo_byte_q #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .push_data(rx_byte),
    .pop(rx_pop_req), .head(rx_head), .count(rx_cnt),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign tx_avail = (tx_cnt != '0);
  assign rx_space = (rx_cnt != CNT_W'(DEPTH));

  // named internal events
  logic tx_drain, tx_full_lvl, rx_high_lvl;
  assign tx_drain    = tx_pop_ok && !tx_push_ok && (tx_cnt == CNT_W'(1));
  assign tx_full_lvl = (tx_cnt == CNT_W'(DEPTH));
  assign rx_high_lvl = hi_reached(8'(rx_cnt), hi_thr);

  logic [IRQ_W-1:0] set_vec;
  always_comb begin
    set_vec          = '0;
    set_vec[B_NACK]  = ev_addr_nack;
    set_vec[B_AACK]  = ev_addr_ack;
    set_vec[B_DONE]  = ev_done;
    set_vec[B_ARB]   = ev_arb_lost;
    set_vec[B_FULL]  = tx_full_lvl;
    set_vec[B_EMPTY] = tx_drain;
    set_vec[B_HIGH]  = rx_high_lvl;
    set_vec[B_BERR]  = ev_bus_err;
  end

  logic [IRQ_W-1:0] ien, stat;
  mfifo_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en_wr(ien_wr), .clr_wr(istat_wr),
    .wdata(reg_wdata), .set_vec(set_vec), .en(ien), .stat(stat), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      RA_RXDATA: reg_rdata = {24'd0, rx_head};
      RA_FCTL:   reg_rdata = {16'd0, hi_thr, lo_thr};
      RA_LEVEL:  reg_rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
      RA_IEN:    reg_rdata = ien;
      RA_ISTAT:  reg_rdata = stat;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mfifo_chk.sv
module mfifo_chk
  import mfifo_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [2:0]                 reg_addr,
  input logic [31:0]                reg_wdata,
  input logic                       tx_push_req,
  input logic                       tx_pop,
  input logic                       rx_push,
  input logic                       rx_pop_req,
  input logic                       ev_done,
  input logic                       flush,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic [7:0]                 hi_thr,
  input logic [IRQ_W-1:0]           ien,
  input logic [IRQ_W-1:0]           stat,
  input logic                       irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CNT_W'(DEPTH) && tx_push_req && !tx_pop && !flush) |=> (tx_cnt == CNT_W'(DEPTH)));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && rx_pop_req && !rx_push) |=> (rx_cnt == '0));

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_cnt == '0) && (rx_cnt == '0));

  p_flush_keeps_ien_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(ien));

  p_high_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_thr != 8'd0 && 8'(rx_cnt) >= hi_thr) |=> stat[B_HIGH]);

  p_drain_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CNT_W'(1) && tx_pop && !tx_push_req && !flush) |=> (stat[B_EMPTY] && tx_cnt == '0));

  p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5 && reg_wdata[B_DONE] && !ev_done) |=> !stat[B_DONE]);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

bind mfifo_top mfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_push_req(tx_push_req), .tx_pop(tx_pop),
  .rx_push(rx_push), .rx_pop_req(rx_pop_req), .ev_done(ev_done),
  .flush(flush), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .hi_thr(hi_thr),
  .ien(ien), .stat(stat), .irq(irq)
);

// File: tb/mfifo_top_tb.sv
module mfifo_top_tb;
  localparam int QD = 128;
  localparam logic [31:0] EN_ALL = 32'h0200381D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        tx_pop = 0;
  logic [7:0]  tx_byte;
  logic        tx_avail;
  logic        rx_push = 0;
  logic [7:0]  rx_byte = 0;
  logic        rx_space;
  logic        ev_addr_nack = 0, ev_addr_ack = 0, ev_done = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic        irq;

  always #4 clk = ~clk;

  mfifo_top #(.DEPTH(QD)) u_dut (.*);

  int n_chk = 0, n_err = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] level_word(input int txn, input int rxn);
    return {16'd0, 8'(txn), 8'(rxn)};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic host_push(input logic [7:0] b);
    reg_write(3'd0, {24'd0, b});
    if (txq.size() < QD) txq.push_back(b);
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
    if (rxq.size() < QD) rxq.push_back(b);
  endtask

  task automatic eng_pop_check(input string tag);
    logic [7:0] got; logic av;
    @(negedge clk); tx_pop = 1; #1 got = tx_byte; av = tx_avail;
    @(negedge clk); tx_pop = 0;
    if (txq.size() > 0) begin
      chk({tag, " R3 tx order"}, {23'd0, av, got}, {23'd0, 1'b1, txq.pop_front()});
    end else begin
      chk({tag, " R4 tx empty"}, {23'd0, av, got}, 32'd0);
    end
  endtask

  task automatic host_pop_check(input string tag);
    logic [31:0] d;
    reg_read(3'd1, d);
    if (rxq.size() > 0) chk({tag, " R3 rx order"}, d, {24'd0, rxq.pop_front()});
    else                chk({tag, " R4 rx empty returns 0"}, d, 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state (R1, R11)
    reg_read(3'd3, d); chk("R1 reset level", d, 32'd0);
    reg_read(3'd5, d); chk("R10 reset status", d, 32'd0);
    reg_read(3'd4, d); chk("R11 reset enable", d, 32'd0);
    reg_read(3'd6, d); chk("R1 unmapped address", d, 32'd0);
    chk("R4 reset tx_avail/rx_space", {30'd0, tx_avail, rx_space}, 32'd1);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);

    // enable register keeps defined bits only (R11)
    reg_write(3'd4, 32'hFFFF_FFFF);
    reg_read(3'd4, d); chk("R11 enable readback", d, EN_ALL);
    reg_write(3'd4, 32'd0);

    // event latching, w1c, irq gating (R9, R10, R11)
    @(negedge clk); ev_done = 1; @(negedge clk); ev_done = 0;
    reg_read(3'd5, d); chk("R9 done latches while disabled", d, 32'h0000_1000);
    chk("R10 irq low while disabled", {31'd0, irq}, 32'd0);
    reg_write(3'd4, 32'h0000_1000);
    chk("R11 irq after enable", {31'd0, irq}, 32'd1);
    reg_write(3'd5, 32'h0000_1000);
    chk("R10 irq after w1c", {31'd0, irq}, 32'd0);
    reg_read(3'd5, d); chk("R10 status after w1c", d, 32'd0);
    @(negedge clk); ev_arb_lost = 1; reg_wr = 1; reg_addr = 3'd5; reg_wdata = 32'h0000_0800;
    @(negedge clk); ev_arb_lost = 0; reg_wr = 0;
    reg_read(3'd5, d); chk("R10 set wins over clear", d, 32'h0000_0800);
    @(negedge clk); ev_addr_nack = 1; ev_addr_ack = 1; ev_bus_err = 1;
    @(negedge clk); ev_addr_nack = 0; ev_addr_ack = 0; ev_bus_err = 0;
    reg_read(3'd5, d); chk("R9 event bit positions", d, 32'h0200_2801);
    reg_write(3'd5, 32'hFFFF_FFFF);
    reg_write(3'd4, 32'd0);

    // fill transmit queue past full (R2, R8), drain in order (R3, R7)
    for (int i = 0; i <= QD; i++) host_push(8'(i * 7 + 3));
    reg_read(3'd3, d); chk("R2 tx level caps at 128", d, level_word(QD, 0));
    reg_read(3'd5, d); chk("R8 full status", d & 32'h10, 32'h10);
    chk("R2 tx_avail when full", {31'd0, tx_avail}, 32'd1);
    for (int i = 0; i < QD; i++) eng_pop_check("drain");
    chk("R2 dropped byte absent", {31'd0, tx_avail}, 32'd0);
    reg_read(3'd5, d); chk("R7 drained status", d & 32'h18, 32'h18);
    eng_pop_check("pop on empty");
    reg_read(3'd3, d); chk("R4 level after empty pop", d, 32'd0);
    host_pop_check("rx empty");
    reg_read(3'd3, d); chk("R4 rx count stays 0", d, 32'd0);
    reg_write(3'd5, 32'hFFFF_FFFF);

    // high-water threshold (R1, R6)
    reg_write(3'd2, 32'h0000_0105);
    reg_read(3'd2, d); chk("R1 fifo control readback", d, 32'h0000_0105);
    reg_read(3'd5, d); chk("R6 no high with empty rx", d, 32'd0);
    eng_push(8'hA5);
    reg_read(3'd5, d); chk("R6 threshold 1 first byte", d, 32'h4);
    reg_write(3'd5, 32'h4);
    reg_read(3'd5, d); chk("R6 re-sets while held", d, 32'h4);
    host_pop_check("thr1");
    reg_write(3'd5, 32'h4);
    reg_read(3'd5, d); chk("R6 stays clear below", d, 32'd0);
    reg_write(3'd2, 32'h0000_0300);
    eng_push(8'h11); eng_push(8'h22);
    reg_read(3'd5, d); chk("R6 below threshold 3", d & 32'h4, 32'd0);
    eng_push(8'h33);
    reg_read(3'd5, d); chk("R6 at threshold 3", d & 32'h4, 32'h4);
    reg_read(3'd3, d); chk("R1 rx level field", d, level_word(0, 3));
    for (int i = 0; i < 3; i++) host_pop_check("thr3");
    reg_write(3'd2, 32'd0);
    reg_write(3'd5, 32'hFFFF_FFFF);

    // queue reset (R5)
    host_push(8'h01); host_push(8'h02); host_push(8'h03);
    eng_push(8'h44); eng_push(8'h55);
    reg_write(3'd4, 32'h0000_1000);
    reg_read(3'd3, d); chk("R1 both levels", d, level_word(3, 2));
    reg_write(3'd2, 32'h0001_0203);
    txq.delete(); rxq.delete();
    reg_read(3'd3, d); chk("R5 reset empties both", d, 32'd0);
    reg_read(3'd4, d); chk("R5 enables unchanged", d, 32'h0000_1000);
    reg_read(3'd2, d); chk("R5 thresholds loaded", d, 32'h0000_0203);
    host_push(8'h9C); eng_pop_check("after reset");
    reg_write(3'd2, 32'd0);
    reg_write(3'd4, 32'd0);

    // constrained random data-path traffic (R2, R3, R4)
    for (int it = 0; it < 3000; it++) begin
      case ($urandom_range(3, 0))
        0: host_push(8'($urandom));
        1: eng_pop_check("random");
        2: eng_push(8'($urandom));
        default: host_pop_check("random");
      endcase
      if (it % 100 == 99) begin
        reg_read(3'd3, d);
        chk("R2 random level", d, level_word(txq.size(), rxq.size()));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule